// File: doc/BRIEF.md
# Chip-Select Minimum Gap Enforcer

This block sits between a transaction requester and the active-low chip-select line of a serial peripheral bus. It makes sure the line stays high for at least a programmable number of microseconds between one transaction ending and the next one starting. The requester pulses `begin_req` to open a transaction and `end_req` to close it. The block raises `grant` for one cycle at the moment it actually drives chip-select low. Time is counted with a one-cycle `us_tick` pulse that arrives once per microsecond.

The gap is measured from the last deassertion, so a requester that has already been idle for part of the gap waits only for what is left. No wait is applied when the gap value is zero, or when no deassertion has been recorded since reset. The elapsed-time counter saturates at its maximum, so a very long idle period never wraps around into a false wait.

The controller has three states. `CSG_IDLE` means chip-select is high and no request is pending. `CSG_WAIT` means a begin request is held until the gap has passed. `CSG_ACTIVE` means chip-select is low. The transitions are:

- IDLE to ACTIVE: a begin request arrives and the gap is already satisfied.
- IDLE to WAIT: a begin request arrives and part of the gap is still outstanding.
- WAIT to ACTIVE: the gap has become satisfied.
- ACTIVE to IDLE: an end request arrives; this also restarts the elapsed count and records the deassertion.

Top module: `cs_gap_enforcer`

## Requirements
- R1: Synchronous active-high reset drives `cs_n` to 1 and `grant` to 0, and forgets any recorded deassertion, so the first begin request after reset is never delayed.
- R2: `cs_n` is 0 exactly from the cycle of the grant up to and including the clock edge that samples the closing end request; at every other time it is 1.
- R3: When no deassertion has been recorded since reset, a begin request sampled at an edge drives `cs_n` low at that same edge, whatever the value of `gap_us`.
- R4: When `gap_us` is 0, a begin request (or a held request) drives `cs_n` low at the edge that samples it.
- R5: An end request sampled while `cs_n` is 0 drives `cs_n` to 1 at that edge. It also restarts the elapsed count from zero; a tick sampled at that same edge is not counted.
- R6: While `cs_n` is 1, the gap counts as satisfied at an edge when the number of ticks sampled since the recorded deassertion is at least `gap_us`, read live at that edge. A begin request arriving before that point is held, and `cs_n` goes low at the first edge where the gap is satisfied.
- R7: If the gap is already satisfied when the begin request is sampled, `cs_n` goes low at that edge with no further wait.
- R8: `grant` is 1 for exactly one cycle: the first cycle in which `cs_n` is 0.
- R9: A begin request while a wait is in progress, or while `cs_n` is 0, has no effect. An end request while `cs_n` is 1 has no effect.
- R10: The elapsed count saturates at 2^16-1 ticks. After an idle period longer than that, a begin request with `gap_us` = 65535 is granted immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| begin_req | input | 1 | Request to open a transaction |
| end_req | input | 1 | Request to close the current transaction |
| gap_us | input | 16 | Minimum inactive time in microseconds; 0 disables the wait |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cs_n | output | 1 | Active-low chip-select |
| grant | output | 1 | One-cycle pulse in the first cycle chip-select is low |

## Verification
The bench first tries the first begin after reset with a large gap, which shows whether the "nothing recorded" case is honoured. It then tries a begin issued right after an end with a nonzero gap, which shows whether the full wait happens and whether stray requests during that wait are ignored. A begin after an idle period longer than the gap separates "wait only the remainder" from "always wait the whole gap". A zero gap tells the disable path apart from the timed path. An idle period beyond the counter range, with the largest gap, tells a saturating counter from a wrapping one. A cycle-level behavioural model runs alongside the design and flags any cycle in which `cs_n` or `grant` differs from it.

// File: rtl/cs_gap_pkg.sv
package cs_gap_pkg;

    typedef enum logic [1:0] {
        CSG_IDLE   = 2'd0,
        CSG_WAIT   = 2'd1,
        CSG_ACTIVE = 2'd2
    } csg_state_t;

endpackage

// File: rtl/cs_gap_timer.sv
// Saturating microsecond counter since the last chip-select release,
// plus a flag telling whether any release has been recorded yet.
module cs_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] elapsed,
    output logic             history
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] elapsed_q;
    logic             history_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
            history_q <= 1'b0;
        end else if (restart) begin
            elapsed_q <= '0;
            history_q <= 1'b1;
        end else if (tick && (elapsed_q != CNT_MAX)) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign elapsed = elapsed_q;
    assign history = history_q;

    // R10: once at the ceiling the count stays there until restarted
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        (elapsed_q == CNT_MAX && !restart) |=> (elapsed_q == CNT_MAX));

    // R5: a recorded release always leaves the history flag set
    a_r5_history_kept: assert property (@(posedge clk) disable iff (rst)
        history_q |=> history_q);

endmodule

// File: rtl/cs_gap_judge.sv
// Decides whether the minimum inactive time has been met.
module cs_gap_judge #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] elapsed,
    input  logic             history,
    output logic             gap_met
);
    logic gap_off;
    logic waited_enough;

    always_comb begin
        gap_off       = (gap == '0);
        waited_enough = (elapsed >= gap);
        gap_met       = gap_off || !history || waited_enough;
    end

endmodule

// File: rtl/cs_gap_fsm.sv
// Transaction controller: idle, held request, active chip-select.
module cs_gap_fsm
    import cs_gap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic begin_req,
    input  logic end_req,
    input  logic gap_met,
    output logic cs_n,
    output logic grant,
    output logic restart
);
    csg_state_t state_q, state_d;
    logic       cs_n_q;
    logic       grant_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CSG_IDLE: begin
                if (begin_req) begin
                    state_d = gap_met ? CSG_ACTIVE : CSG_WAIT;
                end
            end
            CSG_WAIT: begin
                if (gap_met) begin
                    state_d = CSG_ACTIVE;
                end
            end
            CSG_ACTIVE: begin
                if (end_req) begin
                    state_d = CSG_IDLE;
                end
            end
            default: state_d = CSG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CSG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= 1'b1;
            grant_q <= 1'b0;
        end else begin
            cs_n_q  <= (state_d != CSG_ACTIVE);
            grant_q <= (state_d == CSG_ACTIVE) && (state_q != CSG_ACTIVE);
        end
    end

    assign restart = (state_q == CSG_ACTIVE) && end_req;
    assign cs_n    = cs_n_q;
    assign grant   = grant_q;

    // R6: a held request stays held while the judge says the gap is unmet
    a_r6_wait_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == CSG_WAIT && !gap_met) |=> (state_q == CSG_WAIT && cs_n_q));

    // R9: an open transaction is closed only by an end request
    a_r9_active_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == CSG_ACTIVE && !end_req) |=> (state_q == CSG_ACTIVE));

    // R8: the grant never lasts beyond one cycle
    a_r8_grant_pulse: assert property (@(posedge clk) disable iff (rst)
        grant_q |=> !grant_q);

endmodule

// File: rtl/cs_gap_enforcer.sv
module cs_gap_enforcer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             begin_req,
    input  logic             end_req,
    input  logic [GAP_W-1:0] gap_us,
    input  logic             us_tick,
    output logic             cs_n,
    output logic             grant
);
    logic [GAP_W-1:0] elapsed;
    logic             history;
    logic             gap_met;
    logic             restart;

    cs_gap_timer #(.CNT_W(GAP_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (us_tick),
        .elapsed (elapsed),
        .history (history)
    );

    cs_gap_judge #(.CNT_W(GAP_W)) u_judge (
        .gap     (gap_us),
        .elapsed (elapsed),
        .history (history),
        .gap_met (gap_met)
    );

    cs_gap_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .begin_req (begin_req),
        .end_req   (end_req),
        .gap_met   (gap_met),
        .cs_n      (cs_n),
        .grant     (grant),
        .restart   (restart)
    );

    // R8: the grant coincides with chip-select being low
    a_r8_grant_low: assert property (@(posedge clk) disable iff (rst)
        grant |-> !cs_n);

    // R2: every falling edge of chip-select carries a grant
    a_r2_fall_granted: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> grant);

    // R5: an end request while active releases chip-select
    a_r5_end_release: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && end_req) |=> cs_n);

    // R4: with a zero gap a pending or new request is never delayed
    a_r4_zero_gap: assert property (@(posedge clk) disable iff (rst)
        (cs_n && begin_req && gap_us == '0) |=> !cs_n);

endmodule

// File: tb/cs_gap_enforcer_test.sv
module cs_gap_enforcer_test;

    localparam int GAP_W   = 16;
    localparam int SAT_MAX = (1 << GAP_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              begin_req = 1'b0;
    logic              end_req = 1'b0;
    logic [GAP_W-1:0]  gap_us = '0;
    logic              us_tick = 1'b0;
    logic              cs_n;
    logic              grant;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int tick_div = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 0;     // 0 idle, 1 waiting, 2 active
    bit m_seen = 1'b0;
    int m_ticks = 0;
    bit m_cs_n = 1'b1;
    bit m_grant = 1'b0;

    always #5 clk = ~clk;

    cs_gap_enforcer #(.GAP_W(GAP_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .begin_req (begin_req),
        .end_req   (end_req),
        .gap_us    (gap_us),
        .us_tick   (us_tick),
        .cs_n      (cs_n),
        .grant     (grant)
    );

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_range(input string req, input string what,
                               input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // tick source, driven away from the active edge
    always @(negedge clk) begin
        if (tick_div == 0) begin
            us_tick  <= 1'b0;
            tick_cnt <= 0;
        end else if (tick_cnt >= tick_div - 1) begin
            us_tick  <= 1'b1;
            tick_cnt <= 0;
        end else begin
            us_tick  <= 1'b0;
            tick_cnt <= tick_cnt + 1;
        end
    end

    // behavioural reference, compared on every clock (R2, R8)
    always @(posedge clk) begin
        bit ok;
        bit cleared;
        cycles++;
        if (rst) begin
            m_mode = 0; m_seen = 0; m_ticks = 0; m_cs_n = 1; m_grant = 0;
        end else begin
            ok = (gap_us == 0) || !m_seen || (m_ticks >= int'(gap_us));
            cleared = 1'b0;
            m_grant = 1'b0;
            if (m_mode == 0) begin
                if (begin_req) begin
                    if (ok) begin m_mode = 2; m_grant = 1; end
                    else m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (ok) begin m_mode = 2; m_grant = 1; end
            end else begin
                if (end_req) begin
                    m_mode = 0; m_seen = 1; m_ticks = 0; cleared = 1;
                end
            end
            if (!cleared && us_tick && m_ticks < SAT_MAX) m_ticks++;
            m_cs_n = (m_mode != 2);
        end
        #2;
        if (!done) begin
            check_bit("R2", "cs_n vs model", cs_n, m_cs_n);
            check_bit("R8", "grant vs model", grant, m_grant);
        end
    end

    task automatic pulse_begin();
        @(negedge clk) begin_req = 1'b1;
        @(negedge clk) begin_req = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk) end_req = 1'b1;
        @(negedge clk) end_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        wait (cycles > 190000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    initial begin
        int waited;
        idle(3);
        // R1: reset values
        check_bit("R1", "cs_n in reset", cs_n, 1'b1);
        check_bit("R1", "grant in reset", grant, 1'b0);
        @(negedge clk) rst = 1'b0;

        // R3: no history, large gap, immediate
        gap_us = 16'd20;
        tick_div = 2;
        pulse_begin();
        check_bit("R3", "cs_n after first begin", cs_n, 1'b0);
        check_bit("R8", "grant on first low cycle", grant, 1'b1);
        @(negedge clk);
        check_bit("R8", "grant drops", grant, 1'b0);

        // R9: begin while active has no effect
        pulse_begin();
        idle(3);
        check_bit("R9", "cs_n stays low", cs_n, 1'b0);
        check_bit("R9", "no second grant", grant, 1'b0);

        // R5: end releases
        pulse_end();
        check_bit("R5", "cs_n high after end", cs_n, 1'b1);

        // R6: immediate begin must wait roughly 20 ticks * 2 cycles
        pulse_begin();
        check_bit("R6", "held after begin", cs_n, 1'b1);
        waited = 1;
        idle(5);
        waited += 5;
        pulse_begin();   // R9: extra begin while waiting
        pulse_end();     // R9: end while high
        waited += 4;
        check_bit("R9", "still held", cs_n, 1'b1);
        while (cs_n && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check_range("R6", "cycles waited", waited, 36, 44);
        check_bit("R6", "grant at release", grant, 1'b1);
        idle(2);
        check_bit("R9", "stray end did not close", cs_n, 1'b0);

        // R7: idle past the gap, then begin is immediate
        pulse_end();
        idle(60);
        pulse_begin();
        check_bit("R7", "no wait after long idle", cs_n, 1'b0);

        // R4: zero gap, begin right after end
        pulse_end();
        gap_us = 16'd0;
        pulse_begin();
        check_bit("R4", "zero gap immediate", cs_n, 1'b0);

        // R1: reset forgets history
        pulse_end();
        gap_us = 16'd30;
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        pulse_begin();
        check_bit("R1", "no wait after reset", cs_n, 1'b0);

        // R10: saturation across a very long idle period
        gap_us = 16'hFFFF;
        tick_div = 1;
        pulse_end();
        idle(70000);
        pulse_begin();
        check_bit("R10", "saturated count grants", cs_n, 1'b0);
        pulse_end();
        check_bit("R5", "final release", cs_n, 1'b1);

        idle(4);
        finish_run();
    end

endmodule